// File: doc/BRIEF.md
# Packed-Message Write Aligner

A vector LDPC decoder keeps several quantized messages in each memory word. Every message is held twice, once in the order the check-node units read it and once in the order the variable-node units read it. Reads therefore need no realignment. A word built in one unit's order must be shifted into the other memory's word boundaries before it is written. This block performs that shift. It takes one packed word per cycle and produces words that fit the target layout. Each output word is built only from the word arriving now and the word that arrived just before it.

The offset between the two layouts is given as a lane count k, where 0 <= k < LANES. Output lane j takes lane j+k of the previous word when j+k < LANES. Otherwise it takes lane j+k-LANES of the current word. The first word of a block only loads the history register. The last word of a block is followed by one extra flush word, zero-filled where no data remains. When k is zero, every word goes straight through unchanged, one cycle later, and no flush word is added. The offset is captured on the first word of each block and held until the block ends.

Top module: `msg_write_aligner`

## Requirements
- R1: After reset, out_valid is 0 and out_word is all zeros until the first valid input word.
- R2: With offset 0, each valid input word appears unchanged on out_word with out_valid high one cycle after its clock edge, and no flush word follows the last word.
- R3: With offset k > 0, each non-first word of a block yields one output word one cycle later. Lane i occupies bits [MSG_W*i +: MSG_W]. Output lane j equals previous-word lane j+k for j < LANES-k, and current-word lane j+k-LANES otherwise. An offset of LANES or more at a block's first word is illegal.
- R4: With offset k > 0, the first word of a block produces no output in the following cycle.
- R5: With offset k > 0, the cycle after the last word's output carries a flush word. Its lanes j < LANES-k hold last-word lane j+k, and its remaining lanes are zero.
- R6: An idle cycle (in_valid low) inside a block produces no output and does not disturb the pairing of consecutive valid words.
- R7: The offset is sampled at the first word of a block; changes on the offset input before the last word have no effect on that block's outputs, including its flush word.
- R8: After a last word with nonzero offset, the source holds in_valid low for one cycle; a new block may start on the next cycle.
- R9: A block consisting of a single word with offset k > 0 (first and last together) yields no output for that word and exactly one flush word the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_last | input | 1 | Input word is the last of its block |
| in_word | input | MSG_W*LANES | Packed messages in producer order, lane 0 in the low bits |
| offset | input | $clog2(LANES) | Lane offset k between the two layouts, sampled at a block's first word |
| out_valid | output | 1 | out_word is to be written this cycle |
| out_word | output | MSG_W*LANES | Realigned packed word |

## Verification
On every cycle the assertions check several rules. A zero-offset word must reappear unchanged one cycle later. A priming word with a nonzero offset must produce nothing. An idle cycle outside a flush must stay silent. A flush word must follow every nonzero-offset last word. The held offset must stay fixed inside a block. The source must respect the one-cycle gap after such a last word. Only the bench scenarios can show the exact lane contents of merged and flush words for several offsets. They also show that mid-block offset changes are ignored, that pairing survives idle gaps, and that single-word blocks emit exactly one flush.

// File: rtl/wa_pkg.sv
package wa_pkg;

    // What the output stage does at the coming clock edge
    typedef enum logic [1:0] {
        EMIT_NONE  = 2'd0,
        EMIT_PASS  = 2'd1,
        EMIT_MERGE = 2'd2,
        EMIT_FLUSH = 2'd3
    } emit_e;

    typedef struct packed {
        emit_e kind;
        logic  first;
    } step_t;

    function automatic logic emits(input emit_e k);
        return k != EMIT_NONE;
    endfunction

    // Source lane for output lane j at offset s, wrapped into range
    function automatic int src_lane(input int j, input int s, input int lanes);
        return (j + s) % lanes;
    endfunction

    // Whether output lane j at offset s draws from the older word
    function automatic logic from_older(input int j, input int s, input int lanes);
        return (j + s) < lanes;
    endfunction

endpackage

// File: rtl/wa_block_ctrl.sv
module wa_block_ctrl
    import wa_pkg::*;
#(
    parameter int LANES = 6,
    localparam int OFS_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [OFS_W-1:0] offset,
    output logic [OFS_W-1:0] ofs_eff,
    output step_t            step,
    output logic             flush_pend
);

    logic             in_block_q;
    logic [OFS_W-1:0] held_q;
    logic             flush_q;
    logic             first;

    assign first   = in_valid && !in_block_q;
    assign ofs_eff = first ? offset : held_q;

    always_comb begin
        step.first = first;
        if (flush_q) begin
            step.kind = EMIT_FLUSH;
        end else if (in_valid) begin
            if (ofs_eff == '0) begin
                step.kind = EMIT_PASS;
            end else if (first) begin
                step.kind = EMIT_NONE;
            end else begin
                step.kind = EMIT_MERGE;
            end
        end else begin
            step.kind = EMIT_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_block_q <= 1'b0;
            held_q     <= '0;
            flush_q    <= 1'b0;
        end else begin
            if (in_valid) begin
                in_block_q <= !in_last;
            end
            if (first) begin
                held_q <= offset;
            end
            flush_q <= in_valid && in_last && (ofs_eff != '0);
        end
    end

    assign flush_pend = flush_q;

    // R7: held offset cannot move while a block is open
    a_r7_offset_hold: assert property (@(posedge clk) disable iff (rst)
        in_block_q |=> $stable(held_q));

    // R8: source leaves a gap for the flush word
    a_r8_flush_gap: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> !in_valid);

    // R3: offset must be a legal lane count at a block's first word
    a_r3_offset_range: assert property (@(posedge clk) disable iff (rst)
        first |-> (int'(offset) < LANES));

endmodule

// File: rtl/wa_lane_merge.sv
module wa_lane_merge
    import wa_pkg::*;
#(
    parameter int MSG_W = 6,
    parameter int LANES = 6,
    localparam int OFS_W  = $clog2(LANES),
    localparam int WORD_W = MSG_W * LANES
) (
    input  logic [WORD_W-1:0] older,
    input  logic [WORD_W-1:0] newer,
    input  logic [OFS_W-1:0]  ofs,
    output logic [WORD_W-1:0] merged
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [MSG_W-1:0] lane_v;

        always_comb begin
            lane_v = '0;
            for (int s = 0; s < LANES; s++) begin
                if (ofs == OFS_W'(s)) begin
                    if (from_older(j, s, LANES)) begin
                        lane_v = older[src_lane(j, s, LANES)*MSG_W +: MSG_W];
                    end else begin
                        lane_v = newer[src_lane(j, s, LANES)*MSG_W +: MSG_W];
                    end
                end
            end
        end

        assign merged[j*MSG_W +: MSG_W] = lane_v;
    end

endmodule

// File: rtl/wa_out_stage.sv
module wa_out_stage
    import wa_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  step_t             step,
    input  logic [WORD_W-1:0] merged,
    output logic [WORD_W-1:0] prev_q,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q    <= '0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            if (in_valid) begin
                prev_q <= in_word;
            end
            out_valid <= emits(step.kind);
            if (emits(step.kind)) begin
                out_word <= merged;
            end
        end
    end

endmodule

// File: rtl/msg_write_aligner.sv
module msg_write_aligner
    import wa_pkg::*;
#(
    parameter int MSG_W = 6,
    parameter int LANES = 6,
    localparam int OFS_W  = $clog2(LANES),
    localparam int WORD_W = MSG_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_last,
    input  logic [WORD_W-1:0] in_word,
    input  logic [OFS_W-1:0]  offset,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);

    logic [OFS_W-1:0]  ofs_eff;
    step_t             step;
    logic              flush_pend;
    logic [WORD_W-1:0] prev_q;
    logic [WORD_W-1:0] older_src;
    logic [WORD_W-1:0] newer_src;
    logic [WORD_W-1:0] merged;

    wa_block_ctrl #(.LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .offset     (offset),
        .ofs_eff    (ofs_eff),
        .step       (step),
        .flush_pend (flush_pend)
    );

    // Pass-through feeds the current word in as the "older" word at offset 0
    assign older_src = (step.kind == EMIT_PASS)  ? in_word : prev_q;
    assign newer_src = (step.kind == EMIT_FLUSH) ? '0      : in_word;

    wa_lane_merge #(.MSG_W(MSG_W), .LANES(LANES)) u_merge (
        .older  (older_src),
        .newer  (newer_src),
        .ofs    (ofs_eff),
        .merged (merged)
    );

    wa_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .step      (step),
        .merged    (merged),
        .prev_q    (prev_q),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // R2: zero offset reproduces the input word one cycle later
    a_r2_pass: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush_pend && ofs_eff == '0)
        |=> (out_valid && out_word == $past(in_word)));

    // R4: a priming word with nonzero offset emits nothing
    a_r4_prime_silent: assert property (@(posedge clk) disable iff (rst)
        (step.first && !flush_pend && ofs_eff != '0) |=> !out_valid);

    // R5: a flush word follows a nonzero-offset last word
    a_r5_flush_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last && ofs_eff != '0) |=> ##1 out_valid);

    // R6: idle cycles outside a flush stay silent
    a_r6_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !flush_pend) |=> !out_valid);

endmodule

// File: tb/tb_msg_write_aligner.sv
module tb_msg_write_aligner;

    localparam int  MSG_W  = 6;
    localparam int  LANES  = 6;
    localparam int  OFS_W  = $clog2(LANES);
    localparam int  WORD_W = MSG_W * LANES;
    localparam time PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic              in_last;
    logic [WORD_W-1:0] in_word;
    logic [OFS_W-1:0]  offset;
    logic              out_valid;
    logic [WORD_W-1:0] out_word;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    logic              got_v;
    logic [WORD_W-1:0] got_w;

    msg_write_aligner #(.MSG_W(MSG_W), .LANES(LANES)) dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .in_word   (in_word),
        .offset    (offset),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [WORD_W-1:0] mk(input int base);
        logic [WORD_W-1:0] w;
        for (int i = 0; i < LANES; i++) w[i*MSG_W +: MSG_W] = MSG_W'(base + 7*i);
        return w;
    endfunction

    // Expected output per R3/R5: lanes j<LANES-k from older, rest from newer
    function automatic logic [WORD_W-1:0] expect_merge(input logic [WORD_W-1:0] older,
                                                        input logic [WORD_W-1:0] newer,
                                                        input int k);
        logic [WORD_W-1:0] w;
        for (int j = 0; j < LANES; j++) begin
            if (j < LANES - k) w[j*MSG_W +: MSG_W] = older[(j+k)*MSG_W +: MSG_W];
            else               w[j*MSG_W +: MSG_W] = newer[(j+k-LANES)*MSG_W +: MSG_W];
        end
        return w;
    endfunction

    task automatic chk_word(input string req, input logic ev, input logic [WORD_W-1:0] ew);
        n_checks++;
        if (got_v !== ev || (ev && got_w !== ew)) begin
            n_bad++;
            $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
                     req, got_v, got_w, ev, ew);
        end
    endtask

    // Drive at a falling edge, then capture outputs at the next falling edge
    task automatic step(input logic v, input logic l, input logic [WORD_W-1:0] w,
                        input logic [OFS_W-1:0] k);
        in_valid = v;
        in_last  = l;
        in_word  = w;
        offset   = k;
        @(negedge clk);
        got_v = out_valid;
        got_w = out_word;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, offset);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 0; in_last = 0; in_word = '0; offset = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        got_v = out_valid; got_w = out_word;
        chk_word("R1 after reset", 1'b0, '0);
        n_checks++;
        if (out_word !== '0) begin
            n_bad++;
            $display("FAIL R1 word: %h expected 0", out_word);
        end
        idle();
        chk_word("R1 idle after reset", 1'b0, '0);
    endtask

    task automatic t_pass();
        step(1, 0, mk(1), 0);  chk_word("R2 pass w0", 1, mk(1));
        step(1, 0, mk(20), 0); chk_word("R2 pass w1", 1, mk(20));
        step(1, 1, mk(40), 0); chk_word("R2 pass last", 1, mk(40));
        idle();                chk_word("R2 no flush", 0, '0);
    endtask

    task automatic t_merge(input int k, input int base);
        logic [WORD_W-1:0] w [4];
        for (int i = 0; i < 4; i++) w[i] = mk(base + 11*i);
        step(1, 0, w[0], OFS_W'(k)); chk_word("R4 prime silent", 0, '0);
        step(1, 0, w[1], OFS_W'(k)); chk_word("R3 merge 1", 1, expect_merge(w[0], w[1], k));
        step(1, 0, w[2], OFS_W'(k)); chk_word("R3 merge 2", 1, expect_merge(w[1], w[2], k));
        step(1, 1, w[3], OFS_W'(k)); chk_word("R3 merge last", 1, expect_merge(w[2], w[3], k));
        idle();                      chk_word("R5 flush word", 1, expect_merge(w[3], '0, k));
        idle();                      chk_word("R5 single flush", 0, '0);
    endtask

    task automatic t_single();
        step(1, 1, mk(5), 5); chk_word("R9 single word silent", 0, '0);
        idle();               chk_word("R9 flush", 1, expect_merge(mk(5), '0, 5));
        idle();               chk_word("R9 only one flush", 0, '0);
    endtask

    task automatic t_offset_change();
        step(1, 0, mk(3), 1);  chk_word("R7 prime", 0, '0);
        step(1, 0, mk(9), 3);  chk_word("R7 held offset", 1, expect_merge(mk(3), mk(9), 1));
        step(1, 1, mk(15), 0); chk_word("R7 held at last", 1, expect_merge(mk(9), mk(15), 1));
        step(0, 0, '0, 4);     chk_word("R7 flush uses held", 1, expect_merge(mk(15), '0, 1));
    endtask

    task automatic t_gap();
        step(1, 0, mk(30), 3); chk_word("R6 prime", 0, '0);
        idle();                chk_word("R6 gap silent", 0, '0);
        idle();                chk_word("R6 gap silent 2", 0, '0);
        step(1, 1, mk(50), 3); chk_word("R6 pairing kept", 1, expect_merge(mk(30), mk(50), 3));
        idle();                chk_word("R6 flush", 1, expect_merge(mk(50), '0, 3));
    endtask

    task automatic t_back_to_back();
        step(1, 1, mk(60), 2); chk_word("R8 single prime", 0, '0);
        idle();                chk_word("R8 flush in gap", 1, expect_merge(mk(60), '0, 2));
        step(1, 1, mk(8), 0);  chk_word("R8 new block pass", 1, mk(8));
        idle();                chk_word("R8 quiet", 0, '0);
    endtask

    initial begin
        t_reset();
        t_pass();
        t_merge(2, 10);
        t_merge(1, 33);
        t_merge(LANES - 1, 17);
        t_single();
        t_offset_change();
        t_gap();
        t_back_to_back();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule